// File: doc/BRIEF.md
# Dual Programmable Interval Timer

A memory-mapped timer peripheral with one or two independent 32-bit channels; a parameter sets how many. Each channel has three registers: a control/status word, a load value and a live counter. Software writes a load value, then writes the control word to start the channel. The channel counts up or down from the load value. When it runs past its terminal value it raises a sticky expiry flag. It then either reloads and keeps running or stops.

All channels drive a single level interrupt. The interrupt is high while any channel has its expiry flag set together with its interrupt-enable bit. The bus port is a plain word interface: a word address, a write strobe, write data, and read data that is combinational from the address. Bit 2 of the word address selects the channel. Bits 1:0 select the slot: 0 is control/status, 1 is load, 2 is counter, and 3 is unused.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset all registers and counters read zero, every channel is stopped and `irq` is low.
- R2: Control/status keeps only bits 10:0 and reads zero above them. Slot 3 reads zero. Writes to slot 3 and to the counter slot change nothing.
- R3: A control write with bit 7 (run enable) set loads the counter from the load register in that cycle. With bit 1 = 1 the counter then decrements once per cycle. In the cycle after it reads zero, bit 8 (expiry flag) sets. Without auto-reload the channel then stops with the counter held at zero.
- R4: With bit 1 = 0 the counter increments once per cycle. In the cycle after it reads all-ones, bit 8 sets. Without auto-reload the channel then stops with the counter held at all-ones.
- R5: With bit 4 (auto-reload) set, expiry reloads the counter from the load register and counting continues. The flag stays set.
- R6: A control write with bit 8 = 1 clears the expiry flag, and a write with bit 8 = 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: `irq` is the OR over all present channels of (bit 8 AND bit 6, the interrupt enable). It follows every register write and every expiry.
- R8: While bit 5 (load hold) is set, the counter takes the load register value every cycle. It does not count and does not expire.
- R9: A control write with bit 10 (enable-all) set sets bit 7 in every present channel and starts each of them from its own load value. The other control bits of those channels are left unchanged.
- R10: A control write with bit 7 = 0 stops the channel, and the counter then holds its value.
- R11: With one channel, channel 1's addresses (4 to 7) read zero, writes to them have no effect, and that channel never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address: bit 2 selects the channel, bits 1:0 select the slot |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Shared level interrupt |

## Verification
The hardest cases to reach from the ports depend on exact cycles. One is an expiry that lands on the same edge as a flag-clearing write. Another is an expiry at the 32-bit wrap of an up-counter. The bench counts edges from the start write and issues the clearing write exactly on the expiry edge. It reaches the wrap by loading values a few counts below all-ones, so each up-count run is only a handful of cycles long. A second instance built with one channel shares the bus, so every access to channel 1 also checks that the absent channel reads zero and never drives the interrupt.

// File: rtl/dit_pkg.sv
`timescale 1ns/10ps
package dit_pkg;
    localparam int DATA_W = 32;
    localparam int CSR_W  = 11;
    localparam int SLOT_W = 2;
    localparam int MAX_CH = 2;
    localparam int CH_W   = $clog2(MAX_CH);
    localparam int ADDR_W = SLOT_W + CH_W;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_RELOAD = 2'd1,
        SLOT_COUNT  = 2'd2,
        SLOT_SPARE  = 2'd3
    } slot_e;

    // Field order fixes the bit positions seen by software (bit 10 first).
    typedef struct packed {
        logic all_go;       // 10
        logic pwm_sel;      // 9
        logic expired;      // 8
        logic run_en;       // 7
        logic irq_en;       // 6
        logic load_hold;    // 5
        logic auto_rld;     // 4
        logic capture_sel;  // 3
        logic gen_sel;      // 2
        logic count_down;   // 1
        logic mode_sel;     // 0
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic reload;
    } ch_wr_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(DATA_W-CSR_W){1'b0}}, c};
    endfunction

    function automatic logic at_terminal(input logic down, input logic [DATA_W-1:0] cnt);
        return down ? (cnt == '0) : (&cnt);
    endfunction
endpackage

// File: rtl/dit_decode.sv
`timescale 1ns/10ps
module dit_decode
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                  wr_i,
    input  logic [CH_W-1:0]       ch_i,
    input  slot_e                 slot_i,
    input  logic                  all_go_bit_i,
    output ch_wr_t [NUM_CH-1:0]   wr_o,
    output logic                  start_all_o
);
    logic hit;
    logic ctrl_wr;

    always_comb begin
        hit     = ({{(32-CH_W){1'b0}}, ch_i} < NUM_CH);
        ctrl_wr = wr_i && hit && (slot_i == SLOT_CTRL);
        start_all_o = ctrl_wr && all_go_bit_i;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        always_comb begin
            wr_o[i].ctrl   = wr_i && (ch_i == CH_W'(i)) && (slot_i == SLOT_CTRL);
            wr_o[i].reload = wr_i && (ch_i == CH_W'(i)) && (slot_i == SLOT_RELOAD);
        end
    end
endmodule

// File: rtl/dit_channel.sv
`timescale 1ns/10ps
module dit_channel
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ch_wr_t            wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              start_all_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic              expire_o
);
    ctrl_t             ctrl_q, ctrl_n, wr_ctrl;
    logic [DATA_W-1:0] reload_q, count_q, count_n;
    logic              running_q, running_n;
    logic              start, expire, flag_clr;

    always_comb begin
        wr_ctrl  = ctrl_t'(wdata_i[CSR_W-1:0]);
        start    = (wr_i.ctrl && wr_ctrl.run_en) || start_all_i;
        flag_clr = wr_i.ctrl && wr_ctrl.expired;
        expire   = running_q && !ctrl_q.load_hold && at_terminal(ctrl_q.count_down, count_q);
    end

    always_comb begin
        ctrl_n = ctrl_q;
        if (wr_i.ctrl) ctrl_n = wr_ctrl;
        if (start_all_i) ctrl_n.run_en = 1'b1;
        ctrl_n.expired = expire || (ctrl_q.expired && !flag_clr);
    end

    always_comb begin
        if (start)            running_n = 1'b1;
        else if (wr_i.ctrl)   running_n = 1'b0;
        else if (expire)      running_n = ctrl_q.auto_rld;
        else                  running_n = running_q;
    end

    always_comb begin
        if (start || ctrl_q.load_hold) begin
            count_n = reload_q;
        end else if (running_q) begin
            if (expire)                 count_n = ctrl_q.auto_rld ? reload_q : count_q;
            else if (ctrl_q.count_down) count_n = count_q - 1'b1;
            else                        count_n = count_q + 1'b1;
        end else begin
            count_n = count_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            reload_q  <= '0;
            count_q   <= '0;
            running_q <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_n;
            count_q   <= count_n;
            running_q <= running_n;
            if (wr_i.reload) reload_q <= wdata_i;
        end
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign count_o  = count_q;
    assign expire_o = expire;

    assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
        running_q && !ctrl_q.load_hold && ctrl_q.count_down && count_q != '0 && !start && !wr_i.ctrl
        |=> count_q == $past(count_q) - 1'b1);

    assert_stop_on_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        expire && !ctrl_q.auto_rld && !start
        |=> !running_q && count_q == $past(count_q));

    assert_up_step_R4: assert property (@(posedge clk) disable iff (rst)
        running_q && !ctrl_q.load_hold && !ctrl_q.count_down && !(&count_q) && !start && !wr_i.ctrl
        |=> count_q == $past(count_q) + 1'b1);

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        expire && ctrl_q.auto_rld && !start && !wr_i.ctrl
        |=> running_q && count_q == $past(reload_q));

    assert_hold_force_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.load_hold |=> count_q == $past(reload_q));

    assert_stopped_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !running_q && !ctrl_q.load_hold && !start |=> $stable(count_q));
endmodule

// File: rtl/dit_rdmux.sv
`timescale 1ns/10ps
module dit_rdmux
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [CH_W-1:0]                 ch_i,
    input  slot_e                           slot_i,
    input  ctrl_t [NUM_CH-1:0]              ctrl_i,
    input  logic  [NUM_CH-1:0][DATA_W-1:0]  reload_i,
    input  logic  [NUM_CH-1:0][DATA_W-1:0]  count_i,
    output logic  [DATA_W-1:0]              rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_i == CH_W'(i)) begin
                case (slot_i)
                    SLOT_CTRL:   rdata_o = ctrl_to_word(ctrl_i[i]);
                    SLOT_RELOAD: rdata_o = reload_i[i];
                    SLOT_COUNT:  rdata_o = count_i[i];
                    default:     rdata_o = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/10ps
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CH_W-1:0]                 ch_idx;
    slot_e                           slot;
    ch_wr_t [NUM_CH-1:0]             ch_wr;
    logic                            start_all;
    ctrl_t  [NUM_CH-1:0]             ctrl;
    logic   [NUM_CH-1:0][DATA_W-1:0] reload;
    logic   [NUM_CH-1:0][DATA_W-1:0] count;
    logic   [NUM_CH-1:0]             expire;
    logic   [NUM_CH-1:0]             pend;

    assign ch_idx = bus_addr[ADDR_W-1 -: CH_W];
    assign slot   = slot_e'(bus_addr[SLOT_W-1:0]);

    dit_decode #(.NUM_CH(NUM_CH)) u_decode (
        .wr_i         (bus_wr),
        .ch_i         (ch_idx),
        .slot_i       (slot),
        .all_go_bit_i (bus_wdata[CSR_W-1]),
        .wr_o         (ch_wr),
        .start_all_o  (start_all)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dit_channel u_ch (
            .clk         (clk),
            .rst         (rst),
            .wr_i        (ch_wr[i]),
            .wdata_i     (bus_wdata),
            .start_all_i (start_all),
            .ctrl_o      (ctrl[i]),
            .reload_o    (reload[i]),
            .count_o     (count[i]),
            .expire_o    (expire[i])
        );
        assign pend[i] = ctrl[i].expired && ctrl[i].irq_en;
    end

    dit_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .ch_i     (ch_idx),
        .slot_i   (slot),
        .ctrl_i   (ctrl),
        .reload_i (reload),
        .count_i  (count),
        .rdata_o  (bus_rdata)
    );

    assign irq = |pend;

    assert_spare_zero_R2: assert property (@(posedge clk) disable iff (rst)
        slot == SLOT_SPARE |-> bus_rdata == '0);

    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        slot == SLOT_CTRL |-> bus_rdata[DATA_W-1:CSR_W] == '0);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(bus_wr) || $past(|expire));

    assert_irq_drop_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_wr));
endmodule

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/10ps
module dual_interval_timer_tb_top;
    localparam logic [31:0] DIR = 32'h002, ARL = 32'h010, LDH = 32'h020, IEN = 32'h040;
    localparam logic [31:0] TEN = 32'h080, FLG = 32'h100, ENA = 32'h400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata2, rdata1;
    logic        irq2, irq1;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dual_interval_timer #(.NUM_CH(2)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata2), .irq(irq2));

    dual_interval_timer #(.NUM_CH(1)) dut1_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .irq(irq1));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_addr = a;
        #0.05;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a));
            chk("R1 reset read 2ch", rdata2, 32'h0);
            chk("R1 reset read 1ch", rdata1, 32'h0);
        end
        chk("R1 irq", {31'b0, irq2}, 32'h0);

        // R2: masking, spare slot, counter slot read-only
        wr(3'd0, 32'hFFFF_F87F);
        rd(3'd0); chk("R2 ctrl mask", rdata2, 32'h0000_007F);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'hDEAD_BEEF);
        rd(3'd3); chk("R2 spare slot", rdata2, 32'h0);
        wr(3'd1, 32'd9);
        wr(3'd2, 32'h55);
        rd(3'd2); chk("R2 counter write ignored", rdata2, 32'h0);

        // R3: down-count sweep
        for (int l = 0; l < 6; l++) begin
            wr(3'd1, 32'(l));
            wr(3'd0, DIR | TEN | IEN);
            for (int k = 0; k <= l; k++) begin
                rd(3'd2); chk("R3 down count", rdata2, 32'(l - k));
                rd(3'd0); chk("R3 flag clear during run", rdata2 & FLG, 32'h0);
                tick(1);
            end
            rd(3'd0); chk("R3 flag on expiry", rdata2 & FLG, FLG);
            chk("R7 irq on expiry", {31'b0, irq2}, 32'h1);
            rd(3'd2); chk("R3 held at zero", rdata2, 32'h0);
            tick(2);
            rd(3'd2); chk("R3 stopped", rdata2, 32'h0);
            wr(3'd0, FLG);
            rd(3'd0); chk("R6 flag cleared", rdata2, 32'h0);
            chk("R7 irq cleared", {31'b0, irq2}, 32'h0);
        end

        // R4: up-count sweep near the wrap
        for (int m = 0; m < 4; m++) begin
            wr(3'd1, 32'hFFFF_FFFF - 32'(m));
            wr(3'd0, TEN | IEN);
            for (int k = 0; k <= m; k++) begin
                rd(3'd2); chk("R4 up count", rdata2, 32'hFFFF_FFFF - 32'(m) + 32'(k));
                tick(1);
            end
            rd(3'd0); chk("R4 flag on wrap", rdata2 & FLG, FLG);
            tick(1);
            rd(3'd2); chk("R4 held at all-ones", rdata2, 32'hFFFF_FFFF);
            wr(3'd0, FLG);
        end

        // R5: auto-reload
        wr(3'd1, 32'd3);
        wr(3'd0, DIR | TEN | ARL);
        for (int k = 0; k < 12; k++) begin
            rd(3'd2); chk("R5 reload sequence", rdata2, 32'(3 - (k % 4)));
            rd(3'd0); chk("R5 sticky flag", rdata2 & FLG, (k >= 4) ? FLG : 32'h0);
            tick(1);
        end

        // R10: stop holds the count
        begin
            logic [31:0] held;
            wr(3'd0, FLG | DIR);
            rd(3'd2); held = rdata2;
            tick(3);
            rd(3'd2); chk("R10 stopped count stable", rdata2, held);
            rd(3'd0); chk("R10 ctrl after stop", rdata2, DIR);
        end

        // R6: expiry on the same edge as a clearing write
        wr(3'd1, 32'd2);
        wr(3'd0, DIR | TEN);
        tick(2);
        wr(3'd0, FLG | DIR);
        rd(3'd0); chk("R6 expiry beats clear", rdata2, FLG | DIR);
        wr(3'd0, IEN);
        rd(3'd0); chk("R6 write zero keeps flag", rdata2, FLG | IEN);
        chk("R7 enable with pending flag", {31'b0, irq2}, 32'h1);
        wr(3'd0, FLG);
        chk("R7 irq low after clear", {31'b0, irq2}, 32'h0);

        // R8: load hold
        wr(3'd1, 32'd100);
        wr(3'd0, LDH | TEN | DIR);
        rd(3'd2); chk("R8 hold initial", rdata2, 32'd100);
        tick(3);
        rd(3'd2); chk("R8 no counting", rdata2, 32'd100);
        wr(3'd1, 32'd0);
        tick(1);
        rd(3'd2); chk("R8 follows load", rdata2, 32'd0);
        tick(3);
        rd(3'd0); chk("R8 no expiry", rdata2 & FLG, 32'h0);
        wr(3'd0, 32'h0);

        // R9 / R7 / R11: enable-all and shared interrupt
        wr(3'd1, 32'd10);
        wr(3'd5, 32'd20);
        rd(3'd5); chk("R11 absent load reads zero", rdata1, 32'h0);
        wr(3'd4, DIR | IEN);
        rd(3'd4); chk("R11 absent ctrl reads zero", rdata1, 32'h0);
        wr(3'd0, ENA | DIR);
        rd(3'd2); chk("R9 ch0 started", rdata2, 32'd10);
        rd(3'd6); chk("R9 ch1 started", rdata2, 32'd20);
        rd(3'd4); chk("R9 ch1 enable set", rdata2, DIR | IEN | TEN);
        tick(3);
        rd(3'd2); chk("R9 ch0 counting", rdata2, 32'd7);
        rd(3'd6); chk("R9 ch1 counting", rdata2, 32'd17);
        rd(3'd0); chk("R9 ch0 ctrl", rdata2, ENA | DIR | TEN);
        tick(8);
        rd(3'd0); chk("R7 ch0 flag", rdata2 & FLG, FLG);
        chk("R7 masked flag no irq", {31'b0, irq2}, 32'h0);
        tick(10);
        rd(3'd4); chk("R7 ch1 flag", rdata2 & FLG, FLG);
        chk("R7 ch1 drives irq", {31'b0, irq2}, 32'h1);
        chk("R11 absent channel no irq", {31'b0, irq1}, 32'h0);
        rd(3'd6); chk("R11 absent count reads zero", rdata1, 32'h0);
        wr(3'd4, FLG);
        chk("R7 irq after ch1 clear", {31'b0, irq2}, 32'h0);
        wr(3'd0, FLG);
        rd(3'd0); chk("R6 ch0 cleared", rdata2, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule